// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

The block accepts serial audio on up to eight data lines that share one bit clock and one frame clock, and delivers sixteen 24-bit channel samples in parallel. A three-bit format code chooses how many channels each line carries: two-channel (left/right) framing uses all eight lines, and the four-, eight- and sixteen-slot multiplexed formats use four, two or one line. A frame always carries sixteen channels in total. Lines that the chosen format does not use are not read.

The block runs on a fast system clock and oversamples the bit clock, the frame clock and the data lines. A select input chooses whether data is taken on the rising or the falling bit-clock transition. A falling frame-clock transition opens a frame. The whole sample set is published at the transition that opens the following frame, together with a single-cycle valid strobe, but only if the frame had exactly the expected length. A short frame or a long frame realigns the slot counter and publishes nothing.

Top module: `tdm_audio_rx`

## Requirements
- R1: While `rstN` is low and after reset, `sampleValid` is 0 and `samples` is all zeros.
- R2: With format codes 0, 1, 5, 6 or 7 (two slots per line), line k (0-based) carries channel 2k in slot 0 and channel 2k+1 in slot 1. Channel c (0-based) appears on `samples[c*24 +: 24]`.
- R3: With format code 2 (four slots per line), line k carries channels 4k to 4k+3 in slot order, and lines 4 to 7 are ignored.
- R4: With format code 3 (eight slots per line), line 0 carries channels 0 to 7 and line 1 carries channels 8 to 15. Lines 2 to 7 are ignored.
- R5: With format code 4 (sixteen slots), line 0 carries all sixteen channels in slot order, and lines 1 to 7 are ignored.
- R6: When `fallEdge` is 0, bits are taken on rising `bitClk` transitions. When it is 1, they are taken on falling transitions. Data that changes just after the other transition does not affect the result.
- R7: Each slot is 32 bit periods long. It carries its sample MSB first in its first 24 bits, and its last 8 bits are ignored. The first slot's MSB is taken at the capture edge that follows the one at which `frameClk` is first seen low after being high.
- R8: A complete frame produces exactly one cycle of `sampleValid`, and all sixteen samples change in that same cycle. `samples` holds its value in every other cycle.
- R9: A frame whose next falling frame-clock transition comes earlier or later than slots×32 bit periods is not published. The frame that follows it is received normally. The first frame after reset is never published.
- R10: The format code is sampled only at the transition that opens a frame. A change during a frame does not alter how that frame is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rstN | input | 1 | Active-low synchronous reset |
| bitClk | input | 1 | Serial bit clock |
| frameClk | input | 1 | Left/right clock or frame sync; a falling transition opens a frame |
| serData | input | 8 | Serial data lines, line 0 in bit 0 |
| modeSel | input | 3 | Format code (0/1/5–7 two-slot, 2 four-slot, 3 eight-slot, 4 sixteen-slot) |
| fallEdge | input | 1 | 1 selects the falling bit-clock transition for capture |
| samples | output | 384 | Sixteen 24-bit samples, channel c at bits c*24 +: 24 |
| sampleValid | output | 1 | One-cycle strobe marking a new sample set |

## Verification
The bench drives data that changes one system cycle after the non-capturing transition. A receiver that captured on the wrong bit-clock edge would therefore read every bit one position late, and every sample would be wrong. Frames that are 32 bit periods too short or too long are mixed in: a design that ignored the length check would publish a corrupted set, and one that failed to realign would also garble the following good frame. The format code is switched halfway through a frame. A design that applied the new code at once would scatter the slots to the wrong channels. Unused lines always carry random noise, so reading one of them would show up as a mismatched channel.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  localparam int SLOT_IDX_W = 4;
  localparam int LOG_W      = 3;

  typedef struct packed {
    logic                  capture;
    logic                  shiftEn;
    logic                  wordDone;
    logic                  publish;
    logic [SLOT_IDX_W-1:0] slot;
    logic [LOG_W-1:0]      slotsLog;
  } ctlStrobe_t;

  // log2 of channels per line for a given format code
  function automatic logic [LOG_W-1:0] modeToSlotsLog(input logic [2:0] mode);
    case (mode)
      3'd2:    return 3'd2;
      3'd3:    return 3'd3;
      3'd4:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/tdm_rx_ctrl.sv
module tdm_rx_ctrl
  import tdm_rx_pkg::*;
#(
  parameter int SLOT_W        = 32,
  parameter int SAMPLE_W      = 24,
  parameter int MAX_SLOTS_LOG = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitClk,
  input  logic       frameClk,
  input  logic [2:0] modeSel,
  input  logic       fallEdge,
  output ctlStrobe_t strobes
);

  localparam int SLOT_BITS_LOG = $clog2(SLOT_W);
  localparam int CNT_W         = MAX_SLOTS_LOG + SLOT_BITS_LOG;

  logic             bclkQ, bclkPrev, fsQ, fsLastCap;
  logic             capture, fallDet, atLast;
  logic             frameOk;
  logic [CNT_W-1:0] cnt, frameLast;
  logic [LOG_W-1:0] activeLog;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkQ     <= 1'b0;
      bclkPrev  <= 1'b0;
      fsQ       <= 1'b0;
      fsLastCap <= 1'b0;
    end else begin
      bclkQ    <= bitClk;
      bclkPrev <= bclkQ;
      fsQ      <= frameClk;
      if (capture) fsLastCap <= fsQ;
    end
  end

  always_comb begin
    capture   = fallEdge ? (bclkPrev & ~bclkQ) : (~bclkPrev & bclkQ);
    fallDet   = capture & fsLastCap & ~fsQ;
    frameLast = CNT_W'((32'd1 << (32'(activeLog) + SLOT_BITS_LOG)) - 32'd1);
    atLast    = (cnt == frameLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      frameOk   <= 1'b0;
      activeLog <= 3'd1;
    end else if (capture) begin
      if (fallDet) begin
        cnt       <= '0;
        frameOk   <= 1'b1;
        activeLog <= modeToSlotsLog(modeSel);
      end else if (frameOk) begin
        if (atLast) frameOk <= 1'b0;   // frame overran: drop it
        else        cnt     <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.capture  = capture;
    strobes.shiftEn  = capture & ~fallDet & frameOk;
    strobes.wordDone = capture & ~fallDet & frameOk &
                       (cnt[SLOT_BITS_LOG-1:0] == SLOT_BITS_LOG'(SAMPLE_W-1));
    strobes.publish  = fallDet & frameOk & atLast;
    strobes.slot     = cnt[CNT_W-1 -: SLOT_IDX_W];
    strobes.slotsLog = activeLog;
  end

  // R6: a capture follows a bitClk transition of the selected polarity
  p_edge_sel_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> ($past(bitClk) == !fallEdge));

  // R10: the active format only moves at a frame-opening transition
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(capture && fallDet) |=> $stable(activeLog));

  // R9: an overrun with no frame transition disarms the frame
  p_late_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (capture && !fallDet && frameOk && atLast) |=> !frameOk);

  // R7: word completion only inside the frame's slot range
  p_slot_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wordDone |-> (32'(strobes.slot) < (32'd1 << activeLog)));

  // R7: the bit counter never passes the frame length while armed
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameOk |-> (cnt <= frameLast));

endmodule

// File: rtl/tdm_rx_datapath.sv
module tdm_rx_datapath
  import tdm_rx_pkg::*;
#(
  parameter int LINES    = 8,
  parameter int CHANNELS = 16,
  parameter int SAMPLE_W = 24
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [LINES-1:0]             serData,
  input  ctlStrobe_t                   strobes,
  output logic [CHANNELS*SAMPLE_W-1:0] samples,
  output logic                         sampleValid
);

  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1;

  logic [LINES-1:0]    dataQ;
  logic [SAMPLE_W-1:0] word [LINES];

  always_ff @(posedge clk) begin
    if (!rstN) dataQ <= '0;
    else       dataQ <= serData;
  end

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [SAMPLE_W-2:0] shiftQ;
    always_ff @(posedge clk) begin
      if (!rstN)               shiftQ <= '0;
      else if (strobes.shiftEn) shiftQ <= {shiftQ[SAMPLE_W-3:0], dataQ[l]};
    end
    assign word[l] = {shiftQ, dataQ[l]};
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    logic [SAMPLE_W-1:0]   stageQ, outQ;
    logic [LINE_W-1:0]     lineSel;
    logic [SLOT_IDX_W-1:0] slotSel;
    logic                  hit;

    always_comb begin
      lineSel = LINE_W'(c >> strobes.slotsLog);
      slotSel = SLOT_IDX_W'(c & ((1 << strobes.slotsLog) - 1));
      hit     = strobes.wordDone && (strobes.slot == slotSel);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageQ <= '0;
        outQ   <= '0;
      end else begin
        if (hit)             stageQ <= word[lineSel];
        if (strobes.publish) outQ   <= stageQ;
      end
    end

    assign samples[c*SAMPLE_W +: SAMPLE_W] = outQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) sampleValid <= 1'b0;
    else       sampleValid <= strobes.publish;
  end

  // R8: valid lasts a single cycle
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R8: outputs only move together with valid
  p_hold_samples_r8: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> $stable(samples));

endmodule

// File: rtl/tdm_audio_rx.sv
module tdm_audio_rx
  import tdm_rx_pkg::*;
#(
  parameter int LINES         = 8,
  parameter int CHANNELS      = 16,
  parameter int SAMPLE_W      = 24,
  parameter int SLOT_W        = 32,
  parameter int MAX_SLOTS_LOG = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         bitClk,
  input  logic                         frameClk,
  input  logic [LINES-1:0]             serData,
  input  logic [2:0]                   modeSel,
  input  logic                         fallEdge,
  output logic [CHANNELS*SAMPLE_W-1:0] samples,
  output logic                         sampleValid
);

  ctlStrobe_t strobes;

  tdm_rx_ctrl #(
    .SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W), .MAX_SLOTS_LOG(MAX_SLOTS_LOG)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameClk(frameClk),
    .modeSel(modeSel), .fallEdge(fallEdge), .strobes(strobes)
  );

  tdm_rx_datapath #(
    .LINES(LINES), .CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .serData(serData), .strobes(strobes),
    .samples(samples), .sampleValid(sampleValid)
  );

  // R8: a publish is always one cycle after a capture strobe
  p_valid_after_capture_r8: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $past(strobes.capture));

  // R1: nothing is published while in reset
  always_ff @(posedge clk) begin
    if (!rstN) p_reset_quiet_r1: assert (!strobes.publish);
  end

endmodule

// File: tb/tdm_audio_rx_tb.sv
module tdm_audio_rx_tb;

  logic         clk = 1'b0;
  logic         rstN, bitClk, frameClk, fallEdge;
  logic [7:0]   serData;
  logic [2:0]   modeSel;
  logic [383:0] samples;
  logic         sampleValid;

  int checks = 0, fails = 0, validSeen = 0;
  logic [383:0] snap, lastPub;
  logic [23:0]  prevExp [16];
  logic [23:0]  curExp  [16];
  bit           prevGood = 1'b0;
  string        prevTag  = "R9";
  bit           done     = 1'b0;

  tdm_audio_rx u_dut (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameClk(frameClk),
    .serData(serData), .modeSel(modeSel), .fallEdge(fallEdge),
    .samples(samples), .sampleValid(sampleValid)
  );

  always #5 clk = ~clk;

  always @(negedge clk) if (sampleValid) begin
    validSeen = validSeen + 1;
    snap = samples;
  end

  function automatic int slotsLogOf(input int mode);
    case (mode)
      2: return 2;
      3: return 3;
      4: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int chanOf(input int mode, input int line, input int slot);
    int lg = slotsLogOf(mode);
    if (line >= (16 >> lg)) return -1;
    return (line << lg) + slot;
  endfunction

  task automatic bitPeriod(input logic fs, input logic [7:0] d, input logic edgeSel);
    @(negedge clk) bitClk = edgeSel;          // non-capturing level
    @(negedge clk) begin frameClk = fs; serData = d; end
    @(negedge clk) bitClk = ~edgeSel;         // capturing transition
    @(negedge clk);
  endtask

  task automatic checkPrev(input int vb);
    int bad = -1;
    checks++;
    if (prevGood) begin
      // R8: exactly one valid cycle for a complete frame
      if (validSeen - vb != 1) begin
        fails++;
        $display("FAIL %s R8 valid cycles: actual %0d expected 1", prevTag, validSeen - vb);
      end else begin
        for (int c = 0; c < 16; c++)
          if (bad < 0 && snap[c*24 +: 24] !== prevExp[c]) bad = c;
        checks++;
        if (bad >= 0) begin
          fails++;
          $display("FAIL %s channel %0d: actual %h expected %h",
                   prevTag, bad, snap[bad*24 +: 24], prevExp[bad]);
        end
        lastPub = snap;
      end
    end else begin
      // R9: a dropped frame gives no valid and leaves the outputs alone
      if (validSeen != vb || samples !== lastPub) begin
        fails++;
        $display("FAIL %s R9 dropped frame: actual valid %0d samples %h expected valid 0 samples %h",
                 prevTag, validSeen - vb, samples, lastPub);
      end
    end
  endtask

  task automatic sendFrame(input string tag, input int mode, input bit edgeSel,
                           input int nBits, input int midMode);
    int nominal = 32 << slotsLogOf(mode);
    int vb;
    logic [7:0] d;
    @(negedge clk) begin modeSel = 3'(mode); fallEdge = edgeSel; end
    for (int c = 0; c < 16; c++) curExp[c] = 24'($urandom);
    vb = validSeen;
    for (int t = 0; t < nBits; t++) begin
      if (t == 2) checkPrev(vb);
      if (t == nBits / 2 && midMode != mode) modeSel = 3'(midMode);
      for (int l = 0; l < 8; l++) begin
        int b = t - 1;
        d[l] = 1'($urandom);
        if (t > 0 && b < nominal) begin
          int ch = chanOf(mode, l, b / 32);
          if (ch >= 0 && (b % 32) < 24) d[l] = curExp[ch][23 - (b % 32)];
        end
      end
      bitPeriod((t < nBits / 2) ? 1'b0 : 1'b1, d, edgeSel);
    end
    for (int c = 0; c < 16; c++) prevExp[c] = curExp[c];
    prevGood = (nBits == nominal);
    prevTag  = tag;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog: actual %0d cycles expected completion", 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; bitClk = 1'b0; frameClk = 1'b1; serData = '0;
    modeSel = '0; fallEdge = 1'b0; lastPub = '0; snap = '0;
    repeat (5) @(negedge clk);
    // R1: reset state
    checks++;
    if (sampleValid !== 1'b0 || samples !== '0) begin
      fails++;
      $display("FAIL R1 reset: actual valid %b samples %h expected 0 / 0", sampleValid, samples);
    end
    rstN = 1'b1;
    repeat (3) bitPeriod(1'b1, 8'($urandom), 1'b0);

    sendFrame("R2", 0, 0, 64, 0);        // first frame: R9 check of no publish
    sendFrame("R2", 1, 0, 64, 1);
    sendFrame("R3", 2, 0, 128, 2);
    sendFrame("R4", 3, 0, 256, 3);
    sendFrame("R5", 4, 0, 512, 4);
    sendFrame("R6", 2, 1, 128, 2);
    sendFrame("R6", 0, 1, 64, 0);
    sendFrame("R7", 5, 0, 64, 5);
    sendFrame("R2", 7, 1, 64, 7);
    sendFrame("R9", 3, 0, 224, 3);       // early frame transition
    sendFrame("R9", 2, 0, 160, 2);       // late frame transition
    sendFrame("R8", 2, 1, 128, 2);
    sendFrame("R10", 3, 0, 256, 4);      // format change mid-frame
    sendFrame("R10", 4, 1, 512, 0);
    sendFrame("R10", 0, 0, 64, 3);

    for (int i = 0; i < 14; i++) begin
      int m   = int'($urandom % 8);
      int nom = 32 << slotsLogOf(m);
      int sel = int'($urandom % 6);
      int n   = (sel == 0) ? nom - 32 : (sel == 1) ? nom + 32 : nom;
      sendFrame((m == 2) ? "R3" : (m == 3) ? "R4" : (m == 4) ? "R5" : "R2",
                m, bit'($urandom % 2), n, m);
    end
    sendFrame("R2", 0, 0, 64, 0);        // closes the last random frame

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule